// File: doc/BRIEF.md
# Burst Bus Master Engine

This block runs bursts of reads or writes on a 32-bit, byte-granular shared-bus master port on behalf of a simple local command port. A command gives a start word address, a length, a direction, a byte-lane mask and a lock request. Write words are pulled from the local side one at a time. Read words are returned with a one-cycle valid pulse. When the burst stops, a single completion pulse reports how it ended.

The engine raises the bus cycle line with the first strobe and holds it until the burst is over. It gives every word its own strobe. The slave ends each strobe with an acknowledge, an error or a retry. An error abandons the burst at once. A retry takes the strobe away for one clock and then offers the same word again. Each word may be retried a set number of times. If the lock request is set, the lock line stays high for as long as the cycle line is high.

Top module: `burst_master`

## Requirements
- R1: After reset, bus_cyc, bus_stb, bus_lock, rd_valid and done are low and cmd_ready is high.
- R2: bus_cyc rises together with the first bus_stb of a burst. It stays high without a gap until the clock edge that takes the final termination, and it falls on that edge. bus_stb is never high while bus_cyc is low.
- R3: bus_adr holds word address bits (byte address bits 31..2). It starts at cmd_addr and grows by one after each acknowledged word. While a word waits or is retried, bus_adr and bus_sel do not change. bus_sel equals cmd_sel on every strobe. bus_we is 1 for writes and 0 for reads.
- R4: A read word is captured on the clock edge where bus_ack is high. In the next cycle rd_valid is high for one cycle and rd_data holds that word. Words come out in address order.
- R5: For a write, wr_ready is high only while the engine waits for the next word and bus_stb is low. A word taken with wr_valid and wr_ready is driven on bus_dat_o until the slave acknowledges it.
- R6: An error drops bus_cyc, bus_stb and bus_lock on the edge that samples it. In the next cycle done pulses with done_status 2'b01 and done_index set to the zero-based index of the failing word.
- R7: A retry removes bus_stb for exactly one cycle, and then the same word is strobed again. Each word may be retried up to RETRY_MAX times, and the count restarts after an acknowledge. A retry that arrives after RETRY_MAX retries of the same word ends the burst with done_status 2'b10 and the index of that word.
- R8: If the slave raises more than one termination at once, error wins over retry and retry wins over acknowledge.
- R9: bus_lock equals the command's cmd_lock in every cycle where bus_cyc is high, and it is low when bus_cyc is low.
- R10: After all cmd_len+1 words are acknowledged, done pulses for one cycle with done_status 2'b00 and done_index equal to cmd_len. For a read, the valid pulse of the last word comes in the same cycle as done.
- R11: cmd_ready is low from the cycle after a command is accepted until done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The engine is idle and takes the command |
| cmd_addr | input | AW | Start word address |
| cmd_len | input | LW | Number of words minus one |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_sel | input | DW/8 | Byte-lane mask used for every word |
| cmd_lock | input | 1 | Keep the bus locked for the whole burst |
| wr_valid | input | 1 | A local write word is available |
| wr_ready | output | 1 | The engine takes a write word |
| wr_data | input | DW | Local write word |
| rd_valid | output | 1 | One-cycle pulse: a read word is on rd_data |
| rd_data | output | DW | Captured read word |
| done | output | 1 | One-cycle pulse: the burst has ended |
| done_status | output | 2 | 00 complete, 01 error, 10 retries used up |
| done_index | output | LW | Index of the last or failing word |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_stb | output | 1 | Word transfer strobe |
| bus_we | output | 1 | Write enable |
| bus_lock | output | 1 | Uninterruptible cycle request |
| bus_adr | output | AW | Word address |
| bus_sel | output | DW/8 | Byte-lane selects |
| bus_dat_o | output | DW | Write data to the slave |
| bus_dat_i | input | DW | Read data from the slave |
| bus_ack | input | 1 | Normal termination |
| bus_err | input | 1 | Error termination |
| bus_rty | input | 1 | Retry termination |

## Verification
Two things can meet in one clock. The last acknowledged read word and the completion pulse land in the same cycle, and the slave can raise acknowledge together with error or with retry. The bench provokes the first with read bursts of one word and of several words. The scoreboard must pop the read word before the completion record, and both must be present in that cycle. The bench provokes the second with scripted slave replies that raise two terminations at once. It judges them by the completion status, by whether read words appear, and by the one-cycle strobe gap that must follow when retry and acknowledge meet.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_STROBE = 2'd2,
        ST_GAP    = 2'd3
    } bm_state_e;

    typedef enum logic [1:0] {
        END_OK        = 2'b00,
        END_ERR       = 2'b01,
        END_RTY_SPENT = 2'b10
    } bm_end_e;

endpackage

// File: rtl/bm_word_ptr.sv
module bm_word_ptr #(
    parameter int unsigned AW = 30,
    parameter int unsigned LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [LW-1:0] index,
    output logic          last
);

    logic [AW-1:0] addr_d, addr_q;
    logic [LW-1:0] idx_d, idx_q;
    logic [LW-1:0] len_d, len_q;

    always_comb begin
        addr_d = addr_q;
        idx_d  = idx_q;
        len_d  = len_q;
        if (load) begin
            addr_d = load_addr;
            idx_d  = '0;
            len_d  = load_len;
        end else if (step) begin
            addr_d = addr_q + 1'b1;
            idx_d  = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            idx_q  <= '0;
            len_q  <= '0;
        end else begin
            addr_q <= addr_d;
            idx_q  <= idx_d;
            len_q  <= len_d;
        end
    end

    assign addr  = addr_q;
    assign index = idx_q;
    assign last  = (idx_q == len_q);

    // The controller must never step past the final word (R10)
    assert_step_not_last_R10: assert property (@(posedge clk) disable iff (rst)
        step |-> !last);

endmodule

// File: rtl/bm_retry_ctr.sv
module bm_retry_ctr #(
    parameter int unsigned LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic spent
);

    localparam int unsigned RW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;
    localparam logic [RW-1:0] LIM = RW'(LIMIT);

    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign spent = (cnt_q == LIM);

    // A further retry must end the burst rather than count (R7)
    assert_no_bump_when_spent_R7: assert property (@(posedge clk) disable iff (rst)
        bump |-> !spent);

endmodule

// File: rtl/burst_master.sv
module burst_master #(
    parameter int unsigned AW        = 30,
    parameter int unsigned DW        = 32,
    parameter int unsigned LW        = 8,
    parameter int unsigned RETRY_MAX = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_write,
    input  logic [DW/8-1:0] cmd_sel,
    input  logic          cmd_lock,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic [1:0]    done_status,
    output logic [LW-1:0] done_index,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic          bus_we,
    output logic          bus_lock,
    output logic [AW-1:0] bus_adr,
    output logic [DW/8-1:0] bus_sel,
    output logic [DW-1:0] bus_dat_o,
    input  logic [DW-1:0] bus_dat_i,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic          bus_rty
);
    import bm_pkg::*;

    localparam int unsigned SW = DW / 8;

    typedef struct packed {
        bm_state_e     state;
        logic          cyc;
        logic          stb;
        logic          we;
        logic          lock;
        logic          lock_req;
        logic [SW-1:0] sel;
        logic [DW-1:0] dat;
        logic          rd_valid;
        logic [DW-1:0] rd_data;
        logic          done;
        bm_end_e       status;
        logic [LW-1:0] index;
    } regs_t;

    regs_t r_d, r_q;

    logic          ptr_load, ptr_step, ptr_last;
    logic [LW-1:0] ptr_index;
    logic          rty_clear, rty_bump, rty_spent;

    bm_word_ptr #(.AW(AW), .LW(LW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_addr (cmd_addr),
        .load_len  (cmd_len),
        .step      (ptr_step),
        .addr      (bus_adr),
        .index     (ptr_index),
        .last      (ptr_last)
    );

    bm_retry_ctr #(.LIMIT(RETRY_MAX)) u_rty (
        .clk   (clk),
        .rst   (rst),
        .clear (rty_clear),
        .bump  (rty_bump),
        .spent (rty_spent)
    );

    assign cmd_ready = (r_q.state == ST_IDLE);
    assign wr_ready  = (r_q.state == ST_FETCH);

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = 1'b0;
        r_d.done     = 1'b0;
        ptr_load     = 1'b0;
        ptr_step     = 1'b0;
        rty_clear    = 1'b0;
        rty_bump     = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ptr_load     = 1'b1;
                    rty_clear    = 1'b1;
                    r_d.we       = cmd_write;
                    r_d.sel      = cmd_sel;
                    r_d.lock_req = cmd_lock;
                    if (cmd_write) begin
                        r_d.state = ST_FETCH;
                    end else begin
                        r_d.state = ST_STROBE;
                        r_d.cyc   = 1'b1;
                        r_d.stb   = 1'b1;
                        r_d.lock  = cmd_lock;
                    end
                end
            end

            ST_FETCH: begin
                if (wr_valid) begin
                    r_d.dat   = wr_data;
                    r_d.state = ST_STROBE;
                    r_d.cyc   = 1'b1;
                    r_d.stb   = 1'b1;
                    r_d.lock  = r_q.lock_req;
                end
            end

            ST_STROBE: begin
                if (bus_err) begin
                    r_d.state  = ST_IDLE;
                    r_d.cyc    = 1'b0;
                    r_d.stb    = 1'b0;
                    r_d.lock   = 1'b0;
                    r_d.done   = 1'b1;
                    r_d.status = END_ERR;
                    r_d.index  = ptr_index;
                end else if (bus_rty) begin
                    if (rty_spent) begin
                        r_d.state  = ST_IDLE;
                        r_d.cyc    = 1'b0;
                        r_d.stb    = 1'b0;
                        r_d.lock   = 1'b0;
                        r_d.done   = 1'b1;
                        r_d.status = END_RTY_SPENT;
                        r_d.index  = ptr_index;
                    end else begin
                        rty_bump  = 1'b1;
                        r_d.stb   = 1'b0;
                        r_d.state = ST_GAP;
                    end
                end else if (bus_ack) begin
                    rty_clear = 1'b1;
                    if (!r_q.we) begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = bus_dat_i;
                    end
                    if (ptr_last) begin
                        r_d.state  = ST_IDLE;
                        r_d.cyc    = 1'b0;
                        r_d.stb    = 1'b0;
                        r_d.lock   = 1'b0;
                        r_d.done   = 1'b1;
                        r_d.status = END_OK;
                        r_d.index  = ptr_index;
                    end else begin
                        ptr_step = 1'b1;
                        if (r_q.we) begin
                            r_d.stb   = 1'b0;
                            r_d.state = ST_FETCH;
                        end
                    end
                end
            end

            ST_GAP: begin
                r_d.stb   = 1'b1;
                r_d.state = ST_STROBE;
            end

            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_cyc     = r_q.cyc;
    assign bus_stb     = r_q.stb;
    assign bus_we      = r_q.we;
    assign bus_lock    = r_q.lock;
    assign bus_sel     = r_q.sel;
    assign bus_dat_o   = r_q.dat;
    assign rd_valid    = r_q.rd_valid;
    assign rd_data     = r_q.rd_data;
    assign done        = r_q.done;
    assign done_status = r_q.status;
    assign done_index  = r_q.index;

    assert_stb_in_cyc_R2: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> bus_cyc);

    assert_hold_while_waiting_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_ack && !bus_err && !bus_rty)
            |=> (bus_stb && $stable(bus_adr) && $stable(bus_sel)));

    assert_read_pulse_only_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !bus_we);

    assert_error_abandons_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_err) |=> (!bus_cyc && !bus_lock && done));

    assert_retry_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_rty && !bus_err) |=> !bus_stb);

    assert_lock_in_cyc_R9: assert property (@(posedge clk) disable iff (rst)
        bus_lock |-> bus_cyc);

    assert_status_code_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_status != 2'b11));

    assert_busy_no_cmd_R11: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> !cmd_ready);

endmodule

// File: tb/sim_burst_master.sv
module sim_burst_master;

    localparam int unsigned AW   = 30;
    localparam int unsigned DW   = 32;
    localparam int unsigned LW   = 8;
    localparam int unsigned RMAX = 3;
    localparam int unsigned SW   = DW / 8;

    // Slave reply codes used by the script
    localparam logic [2:0] C_ACK    = 3'd0;
    localparam logic [2:0] C_ERR    = 3'd1;
    localparam logic [2:0] C_RTY    = 3'd2;
    localparam logic [2:0] C_WAIT   = 3'd3;
    localparam logic [2:0] C_ERRACK = 3'd4;
    localparam logic [2:0] C_RTYACK = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr  = '0;
    logic [LW-1:0] cmd_len   = '0;
    logic          cmd_write = 1'b0;
    logic [SW-1:0] cmd_sel   = '0;
    logic          cmd_lock  = 1'b0;
    logic          wr_valid  = 1'b0;
    logic          wr_ready;
    logic [DW-1:0] wr_data   = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          done;
    logic [1:0]    done_status;
    logic [LW-1:0] done_index;
    logic          bus_cyc, bus_stb, bus_we, bus_lock;
    logic [AW-1:0] bus_adr;
    logic [SW-1:0] bus_sel;
    logic [DW-1:0] bus_dat_o;
    logic [DW-1:0] bus_dat_i;
    logic          bus_ack, bus_err, bus_rty;

    logic [2:0] fcode = C_ACK;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {8'hC3, a[23:0]};
    endfunction

    assign bus_ack   = bus_stb && (fcode == C_ACK || fcode == C_ERRACK || fcode == C_RTYACK);
    assign bus_err   = bus_stb && (fcode == C_ERR || fcode == C_ERRACK);
    assign bus_rty   = bus_stb && (fcode == C_RTY || fcode == C_RTYACK);
    assign bus_dat_i = pat(bus_adr);

    burst_master #(.AW(AW), .DW(DW), .LW(LW), .RETRY_MAX(RMAX)) u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_write(cmd_write), .cmd_sel(cmd_sel),
        .cmd_lock(cmd_lock),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .done_status(done_status), .done_index(done_index),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_lock(bus_lock), .bus_adr(bus_adr), .bus_sel(bus_sel),
        .bus_dat_o(bus_dat_o), .bus_dat_i(bus_dat_i),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rty(bus_rty)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard queues
    logic [2:0]    script[$];
    logic [DW-1:0] wq[$];
    logic [DW-1:0] exp_rd[$];
    logic [AW-1:0] exp_wa[$];
    logic [DW-1:0] exp_wd[$];
    logic [1:0]    exp_st[$];
    logic [LW-1:0] exp_ix[$];
    logic          exp_lock = 1'b0;
    logic          exp_we   = 1'b0;
    logic [SW-1:0] exp_sel  = '0;

    // Per-burst observation flags
    bit in_burst = 0, cyc_bad = 0, lock_bad = 0, busy_bad = 0, gap_bad = 0;
    bit we_bad = 0, sel_bad = 0, prev_rty = 0, prev_gap = 0;
    logic [AW-1:0] gap_adr = '0;
    bit spend = 0, wpend = 0;

    // Slave model, write-data feeder and monitor, all at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (spend && script.size() > 0) void'(script.pop_front());
            fcode = (script.size() > 0) ? script[0] : C_ACK;
            spend = bus_stb;

            if (wpend && wq.size() > 0) void'(wq.pop_front());
            wr_valid = (wq.size() > 0);
            wr_data  = (wq.size() > 0) ? wq[0] : '0;
            wpend    = wr_valid && wr_ready;

            // R5/R3: write word accepted by the slave this cycle
            if (bus_stb && bus_we && fcode == C_ACK) begin
                if (exp_wa.size() == 0) begin
                    chk(0, "R5 unexpected write", bus_adr, 0);
                end else begin
                    chk(bus_adr == exp_wa[0], "R3 write address", bus_adr, exp_wa[0]);
                    chk(bus_dat_o == exp_wd[0], "R5 write data", bus_dat_o, exp_wd[0]);
                    void'(exp_wa.pop_front());
                    void'(exp_wd.pop_front());
                end
            end

            // R4: read words in order
            if (rd_valid) begin
                if (exp_rd.size() == 0) begin
                    chk(0, "R4 unexpected read", rd_data, 0);
                end else begin
                    chk(rd_data == exp_rd[0], "R4 read data", rd_data, exp_rd[0]);
                    void'(exp_rd.pop_front());
                end
            end

            // R9 lock tracks cycle; R11 busy; R3 we/sel
            if (bus_lock != (bus_cyc && exp_lock)) lock_bad = 1;
            if (bus_cyc && cmd_ready) busy_bad = 1;
            if (bus_stb && bus_we != exp_we) we_bad = 1;
            if (bus_stb && bus_sel != exp_sel) sel_bad = 1;
            if (bus_cyc) in_burst = 1;
            if (in_burst && !bus_cyc && !done) cyc_bad = 1;

            // R7: one idle cycle then the same word again
            if (prev_gap && !(bus_stb && bus_adr == gap_adr)) gap_bad = 1;
            prev_gap = 0;
            if (prev_rty) begin
                if (bus_stb || !bus_cyc) begin
                    if (!done) gap_bad = 1;
                end else begin
                    prev_gap = 1;
                end
            end
            prev_rty = bus_stb && (fcode == C_RTY || fcode == C_RTYACK);
            gap_adr  = bus_adr;

            if (done) begin
                if (exp_st.size() == 0) begin
                    chk(0, "R10 unexpected done", done_status, 0);
                end else begin
                    chk(done_status == exp_st[0], "R6/R7/R8/R10 done status", done_status, exp_st[0]);
                    chk(done_index == exp_ix[0], "R6/R7/R10 done index", done_index, exp_ix[0]);
                    void'(exp_st.pop_front());
                    void'(exp_ix.pop_front());
                end
                chk(exp_rd.size() == 0, "R10 read words outstanding at done", exp_rd.size(), 0);
                chk(exp_wa.size() == 0, "R5 write words outstanding at done", exp_wa.size(), 0);
                chk(!cyc_bad, "R2 cycle held across burst", cyc_bad, 0);
                chk(!lock_bad, "R9 lock follows request", lock_bad, 0);
                chk(!busy_bad, "R11 no command while busy", busy_bad, 0);
                chk(!gap_bad, "R7 retry gap", gap_bad, 0);
                chk(!we_bad && !sel_bad, "R3 we and sel", {we_bad, sel_bad}, 0);
                in_burst = 0; cyc_bad = 0; lock_bad = 0; busy_bad = 0;
                gap_bad = 0; we_bad = 0; sel_bad = 0;
            end
        end
    end

    // Driver: computes expected items from the reply script, then issues the command
    task automatic burst(input logic [AW-1:0] a, input logic [LW-1:0] len,
                         input logic wr, input logic [SW-1:0] sel, input logic lk,
                         input logic [DW-1:0] seed);
        int i = 0;
        int r = 0;
        int k = 0;
        bit fin = 0;
        logic [2:0] c;
        for (int w = 0; w <= int'(len); w++) begin
            if (wr) wq.push_back(seed ^ (w * 32'h0101_0101));
        end
        while (!fin) begin
            c = (k < script.size()) ? script[k] : C_ACK;
            k++;
            if (c == C_WAIT) begin
                // no termination this cycle
            end else if (c == C_ERR || c == C_ERRACK) begin           // R8: error first
                exp_st.push_back(2'b01); exp_ix.push_back(LW'(i)); fin = 1;
            end else if (c == C_RTY || c == C_RTYACK) begin           // R8: retry over ack
                if (r == int'(RMAX)) begin
                    exp_st.push_back(2'b10); exp_ix.push_back(LW'(i)); fin = 1;
                end else begin
                    r++;
                end
            end else begin
                if (wr) begin
                    exp_wa.push_back(a + AW'(i));
                    exp_wd.push_back(seed ^ (i * 32'h0101_0101));
                end else begin
                    exp_rd.push_back(pat(a + AW'(i)));
                end
                if (i == int'(len)) begin
                    exp_st.push_back(2'b00); exp_ix.push_back(len); fin = 1;
                end else begin
                    i++; r = 0;
                end
            end
        end
        exp_lock = lk; exp_we = wr; exp_sel = sel;
        @(negedge clk);
        cmd_addr = a; cmd_len = len; cmd_write = wr; cmd_sel = sel; cmd_lock = lk;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        wq.delete();
        script.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!bus_cyc && !bus_stb && !bus_lock, "R1 bus idle after reset", {bus_cyc, bus_stb, bus_lock}, 0);
        chk(!rd_valid && !done && cmd_ready, "R1 local side after reset", {rd_valid, done, cmd_ready}, 3'b001);

        // R4/R10: plain read burst of four words
        burst(30'h100, 8'd3, 1'b0, 4'hF, 1'b0, 32'h0);
        // R10: single read word, data valid and done together, locked (R9)
        burst(30'h2000, 8'd0, 1'b0, 4'h1, 1'b1, 32'h0);
        // R5/R3: locked write with waits and a partial mask
        script = '{C_ACK, C_WAIT, C_WAIT, C_ACK, C_ACK};
        burst(30'h340, 8'd2, 1'b1, 4'b0110, 1'b1, 32'hDEAD_BEEF);
        // R7: retries that recover
        script = '{C_ACK, C_RTY, C_RTY, C_ACK, C_ACK};
        burst(30'h400, 8'd2, 1'b0, 4'hF, 1'b0, 32'h0);
        // R7: retry limit reached on word 1
        script = '{C_ACK, C_RTY, C_RTY, C_RTY, C_RTY};
        burst(30'h500, 8'd3, 1'b0, 4'hF, 1'b1, 32'h0);
        // R7: retry count restarts per word
        script = '{C_RTY, C_RTY, C_RTY, C_ACK, C_RTY, C_RTY, C_RTY, C_ACK};
        burst(30'h600, 8'd1, 1'b1, 4'hC, 1'b0, 32'h1234_5678);
        // R6: error in the middle of a read
        script = '{C_ACK, C_ACK, C_ERR};
        burst(30'h700, 8'd5, 1'b0, 4'hF, 1'b0, 32'h0);
        // R6: error on the first word of a locked write
        script = '{C_ERR};
        burst(30'h800, 8'd3, 1'b1, 4'h3, 1'b1, 32'hA5A5_0000);
        // R8: error and acknowledge together
        script = '{C_ERRACK};
        burst(30'h900, 8'd2, 1'b0, 4'hF, 1'b0, 32'h0);
        // R8: retry and acknowledge together
        script = '{C_RTYACK, C_ACK, C_ACK};
        burst(30'hA00, 8'd1, 1'b0, 4'hF, 1'b0, 32'h0);
        // R2: long write burst back to back
        burst(30'h3FFF_FFFE, 8'd4, 1'b1, 4'hF, 1'b0, 32'h0F0F_0F0F);

        chk(exp_st.size() == 0, "R10 all bursts completed", exp_st.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule